// File: doc/BRIEF.md
# Synthesizer Control Bus Slave

This block is the write-only slave on a two-wire serial bus (I2C-style) that loads the control registers of a frequency synthesizer. It oversamples the clock and data lines on the system clock and recognises start and stop conditions. It accepts a module address in which one bit is matched against an external select pin, so two such blocks can share one bus. An accepted address is followed by a subaddress byte. The subaddress picks one of two fixed write sequences: a status byte followed by the reference divider, or the feedback divider alone.

A bus master opens a transfer with a start condition and sends the address, the subaddress and the data bytes. It closes the transfer with a stop condition. The slave pulls the data line low in the ninth clock of every byte it accepts. The status byte drives four switching outputs and four mode outputs. Each 16-bit divider is presented to the synthesizer only as a complete value.

Top module: `tsyn_bus_slave`

## Requirements
- R1: After reset, sw_out, mode_out, r_div and n_div are all zero and ack_o is low.
- R2: The 7-bit address is binary 110010 followed by A1, and the direction bit (byte bit 0) must be 0. Address byte 0xC8|(A1<<1) is acknowledged only when A1 equals addr_sel; acknowledge means ack_o high during the ninth SCL high phase.
- R3: A byte that fails the address match is not acknowledged. The rest of that transfer changes no output and draws no acknowledge.
- R4: A subaddress with bits [4:2] = 001 selects the reference group. The data bytes are written in order to status, r_div[15:8] and r_div[7:0].
- R5: A subaddress with bits [3:2] = 11 selects the feedback group. The data bytes are written in order to n_div[15:8] and n_div[7:0].
- R6: A subaddress that matches neither pattern is acknowledged, and the data bytes after it are acknowledged and change nothing.
- R7: A divider output changes only when its low byte arrives. A transfer that ends after the high byte leaves the divider at its old value.
- R8: Status bits [7:4] drive sw_out[3:0], with bit 7 on sw_out[3] (switching output 1). Status bits [3:0] drive mode_out[3:0]: band select, detector test, detector polarity and pump current.
- R9: A start or stop condition in the middle of a byte discards that partial byte and abandons the transfer. Registers written earlier in the transfer keep their values.
- R10: Data bytes beyond the end of the selected sequence are acknowledged and ignored.
- R11: In an addressed transfer, the subaddress and every data byte are acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, far faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel | input | 1 | Level that address bit A1 must match |
| ack_o | output | 1 | High to pull the data line low (acknowledge) |
| sw_out | output | 4 | Switching output bits, from status [7:4] |
| mode_out | output | 4 | Band, detector test, polarity, current bits, from status [3:0] |
| r_div | output | 16 | Reference divider value |
| n_div | output | 16 | Feedback divider value |

## Verification
Each line crosses two synchronizer flops and one edge register. Detection therefore trails a pin edge by three clocks, and a written register updates one clock after that. The acknowledge rises three clocks after the falling SCL edge that ends the eighth bit, and it falls three clocks after the falling edge of the ninth clock. The bench holds every SCL phase for ten system clocks and samples the acknowledge in the middle of the ninth high phase. It reads the register outputs only after the stop condition has settled, well after the last update is due.

// File: rtl/tsyn_pkg.sv
package tsyn_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_SUB, PH_DATA} phase_t;
  typedef enum logic [1:0] {GRP_NONE, GRP_REF, GRP_FB} group_t;
endpackage

// File: rtl/tsyn_sampler.sv
module tsyn_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_s,
  output logic start_c,
  output logic stop_c
);
  localparam int LINES = 2;
  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain   <= '1;
        prev[g] <= 1'b1;
      end else begin
        chain   <= {chain[STAGES-2:0], raw[g]};
        prev[g] <= chain[STAGES-1];
      end
    end
    assign synced[g] = chain[STAGES-1];
  end

  assign sda_s    = synced[1];
  assign scl_rise = synced[0] & ~prev[0];
  assign scl_fall = ~synced[0] & prev[0];
  assign start_c  = synced[0] & prev[0] & prev[1] & ~synced[1];
  assign stop_c   = synced[0] & prev[0] & ~prev[1] & synced[1];
endmodule

// File: rtl/tsyn_frame_rx.sv
module tsyn_frame_rx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              abort,
  input  logic              ack_want,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_q,
  output logic              ack_o,
  output logic [3:0]        bit_cnt
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W - 1);
  localparam logic [3:0] ACK_SLOT = 4'(BYTE_W);
  localparam logic [3:0] ACK_DONE = 4'(BYTE_W + 1);

  logic [BYTE_W-1:0] shreg;
  logic              ack_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      bit_cnt   <= '0;
      byte_done <= 1'b0;
      byte_q    <= '0;
      ack_o     <= 1'b0;
      ack_pend  <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (byte_done) ack_pend <= ack_want;
      if (abort) begin
        bit_cnt  <= '0;
        ack_o    <= 1'b0;
        ack_pend <= 1'b0;
      end else if (scl_rise) begin
        if (bit_cnt < ACK_SLOT) begin
          shreg   <= {shreg[BYTE_W-2:0], sda_s};
          bit_cnt <= bit_cnt + 4'd1;
          if (bit_cnt == LAST_BIT) begin
            byte_done <= 1'b1;
            byte_q    <= {shreg[BYTE_W-2:0], sda_s};
          end
        end else if (bit_cnt == ACK_SLOT) begin
          bit_cnt <= ACK_DONE;
        end
      end else if (scl_fall) begin
        if (bit_cnt == ACK_SLOT) begin
          ack_o    <= ack_pend;
          ack_pend <= 1'b0;
        end else if (bit_cnt == ACK_DONE) begin
          ack_o   <= 1'b0;
          bit_cnt <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/tsyn_regs.sv
module tsyn_regs
  import tsyn_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  group_t            grp,
  input  logic [2:0]        idx,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [BYTE_W-1:0] status_q,
  output logic [DIV_W-1:0]  r_div,
  output logic [DIV_W-1:0]  n_div
);
  localparam int HI_W = DIV_W - BYTE_W;
  logic [HI_W-1:0] r_hi, n_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      r_div    <= '0;
      n_div    <= '0;
      r_hi     <= '0;
      n_hi     <= '0;
    end else if (wr_en) begin
      unique case (grp)
        GRP_REF: begin
          if (idx == 3'd0) status_q <= wr_byte;
          if (idx == 3'd1) r_hi     <= wr_byte[HI_W-1:0];
          if (idx == 3'd2) r_div    <= {r_hi, wr_byte};
        end
        GRP_FB: begin
          if (idx == 3'd0) n_hi  <= wr_byte[HI_W-1:0];
          if (idx == 3'd1) n_div <= {n_hi, wr_byte};
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tsyn_bus_slave.sv
module tsyn_bus_slave
  import tsyn_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         DIV_W       = 16,
  parameter logic [5:0] ADDR_FIXED  = 6'b110010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             addr_sel,
  output logic             ack_o,
  output logic [3:0]       sw_out,
  output logic [3:0]       mode_out,
  output logic [DIV_W-1:0] r_div,
  output logic [DIV_W-1:0] n_div
);
  localparam int BYTE_W = 8;

  logic scl_rise, scl_fall, sda_s, start_c, stop_c;
  logic byte_done, ack_want, addr_hit;
  logic [BYTE_W-1:0] byte_q, status_q;
  logic [3:0] bit_cnt;
  phase_t phase;
  group_t grp;
  logic [2:0] idx;

  tsyn_sampler #(.STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .start_c(start_c), .stop_c(stop_c)
  );

  tsyn_frame_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .abort(start_c | stop_c), .ack_want(ack_want),
    .byte_done(byte_done), .byte_q(byte_q), .ack_o(ack_o), .bit_cnt(bit_cnt)
  );

  assign addr_hit = (byte_q == {ADDR_FIXED, addr_sel, 1'b0});
  assign ack_want = ((phase == PH_ADDR) && addr_hit) ||
                    (phase == PH_SUB) || (phase == PH_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      grp   <= GRP_NONE;
      idx   <= '0;
    end else if (start_c) begin
      phase <= PH_ADDR;
    end else if (stop_c) begin
      phase <= PH_IDLE;
    end else if (byte_done) begin
      unique case (phase)
        PH_ADDR: phase <= addr_hit ? PH_SUB : PH_IDLE;
        PH_SUB: begin
          phase <= PH_DATA;
          idx   <= '0;
          if (byte_q[4:2] == 3'b001)     grp <= GRP_REF;
          else if (byte_q[3:2] == 2'b11) grp <= GRP_FB;
          else                           grp <= GRP_NONE;
        end
        PH_DATA: if (idx != 3'd7) idx <= idx + 3'd1;
        default: ;
      endcase
    end
  end

  tsyn_regs #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(byte_done && phase == PH_DATA),
    .grp(grp), .idx(idx), .wr_byte(byte_q),
    .status_q(status_q), .r_div(r_div), .n_div(n_div)
  );

  assign sw_out   = status_q[7:4];
  assign mode_out = status_q[3:0];
endmodule

// File: rtl/tsyn_bus_slave_chk.sv
module tsyn_bus_slave_chk
  import tsyn_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        ack_o,
  input logic [3:0]  sw_out,
  input logic [15:0] r_div,
  input logic [15:0] n_div,
  input logic        byte_done,
  input logic        scl_fall,
  input logic        start_c,
  input logic        stop_c,
  input logic [3:0]  bit_cnt,
  input phase_t      phase
);
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !ack_o);
  p_ack_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (bit_cnt >= 4'd8));
  p_ack_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ack_o) |-> $past(scl_fall | start_c | stop_c));
  p_status_by_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sw_out) |-> $past(byte_done));
  p_ref_whole_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(r_div) |-> $past(byte_done));
  p_fb_whole_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(n_div) |-> $past(byte_done));
endmodule

bind tsyn_bus_slave tsyn_bus_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack_o(ack_o), .sw_out(sw_out),
  .r_div(r_div), .n_div(n_div), .byte_done(byte_done),
  .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c),
  .bit_cnt(bit_cnt), .phase(phase)
);

// File: tb/tsyn_bus_slave_test.sv
module tsyn_bus_slave_test;
  localparam int H = 10;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, sel = 1'b0;
  logic ack_o;
  logic [3:0] sw_out, mode_out;
  logic [15:0] r_div, n_div;
  int tests = 0, fails = 0;
  logic [7:0] e_stat;
  logic [15:0] e_r, e_n;
  logic got_ack;

  always #4 clk = ~clk;

  tsyn_bus_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_m & ~ack_o),
    .addr_sel(sel), .ack_o(ack_o), .sw_out(sw_out), .mode_out(mode_out),
    .r_div(r_div), .n_div(n_div)
  );

  task automatic wait_h(int n); repeat (n) @(negedge clk); endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_h(H); scl = 1'b1; wait_h(H);
    sda_m = 1'b0; wait_h(H); scl = 1'b0; wait_h(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_h(H); scl = 1'b1; wait_h(H);
    sda_m = 1'b1; wait_h(H);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wait_h(H); scl = 1'b1; wait_h(H); scl = 1'b0;
    end
  endtask

  task automatic send_byte(logic [7:0] b, output logic acked);
    send_bits(b, 8);
    sda_m = 1'b1; wait_h(H); scl = 1'b1; wait_h(H / 2);
    acked = ack_o; wait_h(H / 2); scl = 1'b0;
  endtask

  task automatic check_regs(string req);
    wait_h(H);
    check(req, {24'd0, sw_out, mode_out}, {24'd0, e_stat});
    check(req, {16'd0, r_div}, {16'd0, e_r});
    check(req, {16'd0, n_div}, {16'd0, e_n});
  endtask

  initial begin
    e_stat = '0; e_r = '0; e_n = '0;
    wait_h(5); rst_n = 1'b1; wait_h(5);
    check_regs("R1");
    check("R1", {31'd0, ack_o}, 32'd0);

    // R2 R3: address sweep over select pin, A1 and direction bit
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 4; a++) begin
        logic hit;
        logic [7:0] d;
        sel = s[0];
        hit = (a[1] == s[0]) && !a[0];
        d = 8'h30 + 8'(s * 4 + a);
        bus_start();
        send_byte(8'hC8 | 8'(a[1] << 1) | 8'(a[0]), got_ack);
        check("R2", {31'd0, got_ack}, {31'd0, hit});
        send_byte(8'h04, got_ack);
        check("R3", {31'd0, got_ack}, {31'd0, hit});
        send_byte(d, got_ack);
        check("R3", {31'd0, got_ack}, {31'd0, hit});
        bus_stop();
        if (hit) e_stat = d;
        check_regs("R3");
      end
    end
    bus_start();
    send_byte(8'h48, got_ack);
    check("R3", {31'd0, got_ack}, 32'd0);
    bus_stop();
    sel = 1'b1;

    // R4 R5 R6 R8 R10 R11: subaddress sweep over the low five bits
    for (int s = 0; s < 32; s++) begin
      logic [7:0] sub, d0, d1, d2;
      sub = 8'(s) | 8'(((s * 7) & 7) << 5);
      d0 = 8'(s * 13 + 5); d1 = 8'(s * 29 + 1); d2 = 8'(s * 71 + 9);
      bus_start();
      send_byte(8'hCA, got_ack);
      check("R2", {31'd0, got_ack}, 32'd1);
      send_byte(sub, got_ack);
      check("R11", {31'd0, got_ack}, 32'd1);
      send_byte(d0, got_ack);
      check("R11", {31'd0, got_ack}, 32'd1);
      send_byte(d1, got_ack);
      check("R11", {31'd0, got_ack}, 32'd1);
      send_byte(d2, got_ack);
      check("R10", {31'd0, got_ack}, 32'd1);
      send_byte(8'hA5, got_ack);
      check("R10", {31'd0, got_ack}, 32'd1);
      bus_stop();
      if (((s >> 2) & 7) == 1) begin
        e_stat = d0; e_r = {d1, d2};
        check_regs("R4");
        check("R8", {28'd0, sw_out}, {28'd0, d0[7:4]});
      end else if (((s >> 2) & 3) == 3) begin
        e_n = {d0, d1};
        check_regs("R5");
      end else begin
        check_regs("R6");
      end
    end

    // R7: high byte only, then stop
    bus_start();
    send_byte(8'hCA, got_ack); send_byte(8'h04, got_ack);
    send_byte(8'h96, got_ack); send_byte(8'h12, got_ack);
    bus_stop();
    e_stat = 8'h96;
    check_regs("R7");
    bus_start();
    send_byte(8'hCA, got_ack); send_byte(8'h0C, got_ack);
    send_byte(8'h77, got_ack);
    bus_stop();
    check_regs("R7");

    // R9: start in the middle of the low divider byte
    bus_start();
    send_byte(8'hCA, got_ack); send_byte(8'h0C, got_ack);
    send_byte(8'h3C, got_ack);
    send_bits(8'hFF, 4);
    bus_start();
    bus_stop();
    check_regs("R9");
    // R9: stop in the middle of the reference low byte, status kept
    bus_start();
    send_byte(8'hCA, got_ack); send_byte(8'h04, got_ack);
    send_byte(8'h69, got_ack); send_byte(8'h44, got_ack);
    send_bits(8'h00, 5);
    bus_stop();
    e_stat = 8'h69;
    check_regs("R9");
    // R9: a following complete transfer still works
    bus_start();
    send_byte(8'hCA, got_ack); send_byte(8'h0C, got_ack);
    send_byte(8'hBE, got_ack); send_byte(8'hEF, got_ack);
    bus_stop();
    e_n = 16'hBEEF;
    check_regs("R9");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule